// File: doc/BRIEF.md
# Single-Wire Host Bit-Frame Engine

This block is the host-side timing engine for an open-drain single-wire bus whose one signal line also powers the client. A local controller hands it one command at a time through a valid/ready handshake. The commands are bus reset (short or long), discovery request, write bit, read bit and idle. For each command the engine pulls the shared line low for the right number of clocks through an output enable, then lets the external pull-up restore it. Where the command asks for it, the engine samples the line at a fixed instant and returns the sampled level with a one-cycle done pulse.

The line is never driven high. The value of a written bit is set only by how long the host holds the line low. A read or discovery frame begins the same way, and a client that wants to answer '0' keeps the line low past the host's release. The line input passes through a two-flop synchronizer. A sample taken at frame cycle N therefore shows the line level of frame cycle N-2. Frame cycle 0 is the first cycle after the command is accepted. Every duration is a parameter counted in clock cycles.

Top module: `swire_host_frame`

## Requirements
- R1: After reset, line_oe is 0, busy is 0, done is 0 and cmd_ready is 1.
- R2: Write (cmd_op=3) holds line_oe high for T_LOW0 cycles when cmd_wbit is 0 and for T_LOW1 cycles when it is 1. busy stays high for T_BIT cycles in both cases.
- R3: Read (cmd_op=4) holds line_oe high for T_RD cycles and busy high for T_BIT cycles. rx_bit returns the line level at frame cycle T_MRS-2: low gives 0 (ACK/'0'), high gives 1 (NACK/'1').
- R4: Discovery (cmd_op=2) holds line_oe high for T_DRR cycles and busy high for T_DRR+T_HTSS cycles. rx_bit returns the line level at frame cycle T_MSDR-2, where 0 means a client is present.
- R5: Short reset (cmd_op=0) holds line_oe high for T_RESET cycles and long reset (cmd_op=1) holds it for T_DSCHG cycles. Each is followed by a released recovery of T_RRT cycles while busy stays high.
- R6: Idle (cmd_op=5, and the unused codes 6 and 7) never asserts line_oe and keeps busy high for T_HTSS cycles.
- R7: done is a single-cycle pulse in the first cycle after the frame ends. busy falls in that same cycle, and cmd_ready equals the inverse of busy.
- R8: A command presented while busy is not accepted and changes neither the running frame's timing nor what follows it.
- R9: rx_bit is 1 after commands that take no sample (reset, write, idle). rx_bit changes only in a cycle where done is high.
- R10: line_oe only goes high in the first cycle of a frame and is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 3 | Command code (0 reset, 1 long reset, 2 discovery, 3 write, 4 read, 5-7 idle) |
| cmd_wbit | input | 1 | Bit value for a write command |
| line_in | input | 1 | Level of the shared line (asynchronous) |
| line_oe | output | 1 | Pull the shared line low when 1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rx_bit | output | 1 | Sampled line level of the last frame |

## Verification
A modelled client on a pulled-up line decodes written bits at a point between the two low lengths, and answers reads and discoveries by stretching the low pulse. The bench can therefore tell when a swapped T_LOW0/T_LOW1 would make the client decode the wrong bit. It also catches a sample point that ignores the synchronizer delay or lands after the client has released the line, which would return 1 where the client answered 0. The bench pokes a reset command into the middle of a running read. A design that accepted it would stretch the frame or start a spurious reset afterwards. Long against short reset lengths, the zero-low idle frames and the unused opcode codes are checked, because a wrong decode there gives the wrong low or busy duration.

// File: rtl/swire_host_frame.sv
module swire_host_frame #(
  parameter int T_LOW0  = 16,
  parameter int T_LOW1  = 4,
  parameter int T_RD    = 3,
  parameter int T_MRS   = 8,
  parameter int T_BIT   = 24,
  parameter int T_HTSS  = 12,
  parameter int T_RESET = 40,
  parameter int T_DSCHG = 100,
  parameter int T_RRT   = 20,
  parameter int T_DRR   = 4,
  parameter int T_MSDR  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       line_in,
  output logic       line_oe,
  output logic       busy,
  output logic       done,
  output logic       rx_bit
);
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXT = mx(mx(T_DSCHG + T_RRT, T_RESET + T_RRT),
                           mx(T_BIT, T_DRR + T_HTSS));
  localparam int CW   = $clog2(MAXT + 1);

  logic          active, use_q, smp_q, done_q, rx_q, s1, s2;
  logic [CW-1:0] cnt, low_len, last, samp_pt;
  logic [CW-1:0] n_low, n_last, n_samp;
  logic          n_use;

  always_comb begin
    n_samp = '0;
    n_use  = 1'b0;
    case (cmd_op)
      3'd0: begin n_low = CW'(T_RESET); n_last = CW'(T_RESET + T_RRT - 1); end
      3'd1: begin n_low = CW'(T_DSCHG); n_last = CW'(T_DSCHG + T_RRT - 1); end
      3'd2: begin
        n_low = CW'(T_DRR); n_last = CW'(T_DRR + T_HTSS - 1);
        n_samp = CW'(T_MSDR); n_use = 1'b1;
      end
      3'd3: begin
        n_low  = cmd_wbit ? CW'(T_LOW1) : CW'(T_LOW0);
        n_last = CW'(T_BIT - 1);
      end
      3'd4: begin
        n_low = CW'(T_RD); n_last = CW'(T_BIT - 1);
        n_samp = CW'(T_MRS); n_use = 1'b1;
      end
      default: begin n_low = '0; n_last = CW'(T_HTSS - 1); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      low_len <= '0;
      last    <= '0;
      samp_pt <= '0;
      use_q   <= 1'b0;
      smp_q   <= 1'b1;
      done_q  <= 1'b0;
      rx_q    <= 1'b1;
      s1      <= 1'b1;
      s2      <= 1'b1;
    end else begin
      s1     <= line_in;
      s2     <= s1;
      done_q <= 1'b0;
      if (!active) begin
        if (cmd_valid) begin
          active  <= 1'b1;
          cnt     <= '0;
          low_len <= n_low;
          last    <= n_last;
          samp_pt <= n_samp;
          use_q   <= n_use;
          smp_q   <= 1'b1;
        end
      end else begin
        if (use_q && cnt == samp_pt) smp_q <= s2;
        if (cnt == last) begin
          active <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= smp_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign line_oe   = active && (cnt < low_len);
  assign busy      = active;
  assign cmd_ready = !active;
  assign done      = done_q;
  assign rx_bit    = rx_q;

  p_oe_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);
  p_oe_rise_at_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $rose(busy));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_end_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> done);
endmodule

// File: tb/swire_host_frame_tb.sv
module swire_host_frame_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;
  localparam int DEC  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wbit = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic cmd_ready, line_oe, busy, done, rx_bit, line;
  logic cl_pull, cl_resp, prev, dec_on, dec_bit;
  int   cc;
  int   n_chk = 0, n_fail = 0;
  bit   fin = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line = !(line_oe || cl_pull);

  swire_host_frame u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wbit(cmd_wbit), .line_in(line), .line_oe(line_oe),
    .busy(busy), .done(done), .rx_bit(rx_bit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b1; cl_pull <= 1'b0; dec_on <= 1'b0; cc <= 0; dec_bit <= 1'b1;
    end else begin
      prev <= line;
      if (prev && !line) begin
        cc <= 1; dec_on <= 1'b1; cl_pull <= !cl_resp;
      end else if (dec_on) begin
        cc <= cc + 1;
        if (cc == HOLD) begin cl_pull <= 1'b0; dec_on <= 1'b0; end
        if (cc == DEC) dec_bit <= line;
      end
    end
  end

  function automatic int exp_low(logic [2:0] op, logic wb);
    case (op)
      3'd0: return 40;
      3'd1: return 100;
      3'd2: return 4;
      3'd3: return wb ? 4 : 16;
      3'd4: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_total(logic [2:0] op);
    case (op)
      3'd0: return 60;
      3'd1: return 120;
      3'd2: return 16;
      3'd3, 3'd4: return 24;
      default: return 12;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic wb, input logic resp,
                     input bit poke, output int nlow, output int nbusy, output logic rb);
    @(negedge clk);
    cl_resp = resp; cmd_op = op; cmd_wbit = wb; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    nlow = 0; nbusy = 0;
    for (int i = 1; i < 400; i++) begin
      if (line_oe) nlow++;
      if (busy) nbusy++;
      if (done) break;
      if (poke && i == 2) begin
        chk("R8 ready low while busy", int'(cmd_ready), 0);
        cmd_op = 3'd0; cmd_valid = 1'b1;
      end
      if (poke && i == 3) cmd_valid = 1'b0;
      @(negedge clk);
    end
    rb = rx_bit;
    chk("R7 busy low with done", int'(busy), 0);
  endtask

  task automatic full(input logic [2:0] op, input logic wb, input logic resp);
    int nl, nb; logic rb; int erx;
    run(op, wb, resp, 1'b0, nl, nb, rb);
    case (op)
      3'd3: begin chk("R2 low length", nl, exp_low(op, wb)); chk("R2 frame length", nb, 24);
                  chk("R2 client decode", int'(dec_bit), int'(wb)); end
      3'd4: begin chk("R3 low length", nl, 3); chk("R3 frame length", nb, 24); end
      3'd2: begin chk("R4 low length", nl, 4); chk("R4 frame length", nb, 16); end
      3'd0, 3'd1: begin chk("R5 low length", nl, exp_low(op, wb));
                        chk("R5 frame length", nb, exp_total(op)); end
      default: begin chk("R6 no low", nl, 0); chk("R6 frame length", nb, 12); end
    endcase
    erx = (op == 3'd2 || op == 3'd4) ? int'(resp) : 1;
    chk((op == 3'd4) ? "R3 rx_bit" : (op == 3'd2) ? "R4 rx_bit" : "R9 rx_bit", int'(rb), erx);
    @(negedge clk);
    chk("R7 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int nl, nb; logic rb;
    void'($urandom(32'd4711));
    cl_resp = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 line_oe", int'(line_oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);

    full(3'd0, 1'b0, 1'b1);
    full(3'd2, 1'b0, 1'b0);
    full(3'd2, 1'b0, 1'b1);
    full(3'd3, 1'b0, 1'b1);
    full(3'd3, 1'b1, 1'b1);
    full(3'd4, 1'b0, 1'b0);
    full(3'd4, 1'b0, 1'b1);
    full(3'd1, 1'b0, 1'b1);
    full(3'd5, 1'b0, 1'b1);
    full(3'd6, 1'b0, 1'b1);
    full(3'd7, 1'b0, 1'b1);

    run(3'd4, 1'b0, 1'b0, 1'b1, nl, nb, rb);
    chk("R8 frame length kept", nb, 24);
    chk("R8 low length kept", nl, 3);
    chk("R8 rx kept", int'(rb), 0);
    repeat (3) @(negedge clk);
    chk("R8 no late accept", int'(busy), 0);
    chk("R8 line released", int'(line_oe), 0);

    for (int k = 0; k < 40; k++) begin
      logic [2:0] op; logic wb, rs;
      op = 3'($urandom % 8);
      wb = 1'($urandom);
      rs = (op == 3'd2 || op == 3'd4) ? 1'($urandom) : 1'b1;
      full(op, wb, rs);
    end

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule